// File: doc/BRIEF.md
# Chained Interrupt Priority Resolver

This block chooses which interrupt a processor core takes next. It serves a set of maskable peripheral sources, 18 by default. Each source has a request flag that the block holds and a 3-bit priority level that software programs. Three fixed sources sit above all maskable ones: a reset request, a watchdog request and a non-maskable request. Their order among themselves is set in hardware.

The block samples the pending requests and the levels when an opcode fetch arrives during the high phase of the system clock. It then waits a software-selected number of cycles before it makes a decision. During that wait it ignores further fetches. A request that arrives during the wait stays pending and is considered at the next sample.

The decision runs through a serial chain of stages. Each stage forwards its own level only when that level is strictly higher than the level coming from upstream, so on a tie the lower-indexed source wins. The winner is taken only if its level exceeds the processor priority level and the interrupt-disable flag is clear. When a request is taken, the block emits a one-cycle accept pulse and an identifier, and captures the old status for saving. It then sets the disable flag, loads the winning level into the processor priority level, and clears the winner's pending flag.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset: no accept pulse, processor level 0, disable flag 1, saved status 0, no pending request.
- R2: Among the sampled maskable sources that are pending, the one with the highest level wins.
- R3: When levels are equal, the source with the lower index wins.
- R4: A source whose level is 0 never wins, even when it is pending.
- R5: A maskable winner is taken only if its level is strictly greater than the processor level and the disable flag is 0. Otherwise nothing is taken and the request stays pending.
- R6: On a take, the block does the following:
  - `acc_o` is high for exactly one cycle.
  - `acc_id_o` gives the source index (0..17).
  - `ps_save_o` holds the prior status as {disable flag, level} in bits [3], [2:0].
  - The disable flag becomes 1.
  - The processor level becomes the winning level.
  - The winner's bit in `req_pend_o` clears.
- R7: The fixed sources ignore the disable flag and the processor level. Reset outranks watchdog, watchdog outranks the non-maskable request, and all three outrank every maskable source. They report identifiers 31, 30 and 29, and each loads the processor level with 7.
- R8: A sample happens only when `fetch_i` and `phase_hi_i` are both high and no decision is outstanding. The decision shows on the outputs dly_sel+1 cycles after the sampling edge. Fetches during the wait are ignored.
- R9: A request raised during the wait is not part of the current decision. It stays pending for the next sample.
- R10: A status write sets the disable flag and the processor level. Clearing the flag after a take lets a request with a higher level nest. A take in the same cycle as a write has precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | NUM_SRC | Per-source request set pulse |
| src_lvl_i | input | NUM_SRC*3 | Per-source priority level, source i in bits [3i+2:3i] |
| nmi_set_i | input | 1 | Non-maskable request pulse |
| wdt_set_i | input | 1 | Watchdog request pulse |
| rst_set_i | input | 1 | Reset interrupt request pulse |
| fetch_i | input | 1 | Opcode fetch strobe |
| phase_hi_i | input | 1 | System clock phase is high |
| dly_sel_i | input | CNT_W | Cycles between sample and decision |
| ps_wr_i | input | 1 | Status write strobe |
| ps_iflag_i | input | 1 | Disable flag value to write |
| ps_ipl_i | input | 3 | Processor level value to write |
| acc_o | output | 1 | One-cycle accept pulse |
| acc_id_o | output | 5 | Identifier of the accepted source |
| ps_save_o | output | 4 | Status captured at accept {flag, level} |
| ipl_o | output | 3 | Current processor priority level |
| iflag_o | output | 1 | Current interrupt-disable flag |
| req_pend_o | output | NUM_SRC | Pending maskable requests |

## Verification
The bench sweeps every ordered pair of distinct maskable sources. Levels are derived from the indices, so ties, zero levels and levels at or below the processor level all occur. A chain that let the downstream stage win a tie would report the higher index. A comparison written as greater-or-equal against the processor level would take requests it must refuse.

Fixed sources are raised while the disable flag is set and a maskable level-7 request is pending. A design that gated them by the flag would stay silent, and one with the wrong order would report the wrong identifier.

Requests raised during the sampling wait, and fetches issued during the wait, must leave the current decision alone. A design that resampled on them would take a request early or shift the pulse. Nesting is checked through the saved status after software clears the flag.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W  = 3;
  localparam int ID_W   = 5;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;
  localparam logic [ID_W-1:0]  ID_NMI  = 5'd29;
  localparam logic [ID_W-1:0]  ID_WDT  = 5'd30;
  localparam logic [ID_W-1:0]  ID_RST  = 5'd31;

  typedef struct packed {
    logic             iflag;
    logic [LVL_W-1:0] ipl;
  } stat_t;
endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
  import irq_prio_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             req_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             up_vld_i,
  input  logic [LVL_W-1:0] up_lvl_i,
  input  logic [ID_W-1:0]  up_id_i,
  output logic             dn_vld_o,
  output logic [LVL_W-1:0] dn_lvl_o,
  output logic [ID_W-1:0]  dn_id_o
);
  logic claim;

  // strictly higher only: an equal level leaves the upstream winner in place
  assign claim = req_i && (lvl_i > up_lvl_i);

  always_comb begin
    if (claim) begin
      dn_vld_o = 1'b1;
      dn_lvl_o = lvl_i;
      dn_id_o  = ID_W'(IDX);
    end else begin
      dn_vld_o = up_vld_i;
      dn_lvl_o = up_lvl_i;
      dn_id_o  = up_id_i;
    end
  end
endmodule

// File: rtl/irq_sample_timer.sv
module irq_sample_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_i,
  input  logic             phase_hi_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             sample_o,
  output logic             eval_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign sample_o = fetch_i && phase_hi_i && !busy_q;
  assign eval_o   = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (sample_o) begin
      busy_d = 1'b1;
      cnt_d  = dly_i;
    end else if (eval_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int CNT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_set_i,
  input  logic [NUM_SRC*LVL_W-1:0] src_lvl_i,
  input  logic                     nmi_set_i,
  input  logic                     wdt_set_i,
  input  logic                     rst_set_i,
  input  logic                     fetch_i,
  input  logic                     phase_hi_i,
  input  logic [CNT_W-1:0]         dly_sel_i,
  input  logic                     ps_wr_i,
  input  logic                     ps_iflag_i,
  input  logic [LVL_W-1:0]         ps_ipl_i,
  output logic                     acc_o,
  output logic [ID_W-1:0]          acc_id_o,
  output logic [LVL_W:0]           ps_save_o,
  output logic [LVL_W-1:0]         ipl_o,
  output logic                     iflag_o,
  output logic [NUM_SRC-1:0]       req_pend_o
);
  localparam int FIX_N = 3;   // [2] reset, [1] watchdog, [0] nmi

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic sample, eval;
  irq_sample_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sn),
    .fetch_i    (fetch_i),
    .phase_hi_i (phase_hi_i),
    .dly_i      (dly_sel_i),
    .sample_o   (sample),
    .eval_o     (eval)
  );

  logic [NUM_SRC-1:0]       pend_q, pend_d;
  logic [FIX_N-1:0]         fix_q, fix_d;
  logic [NUM_SRC-1:0]       snap_req_q, snap_req_d;
  logic [NUM_SRC*LVL_W-1:0] snap_lvl_q, snap_lvl_d;
  logic [FIX_N-1:0]         snap_fix_q, snap_fix_d;
  stat_t                    stat_q, stat_d;
  logic                     acc_q, acc_d;
  logic [ID_W-1:0]          id_q, id_d;
  stat_t                    save_q, save_d;

  // serial priority chain, index 0 at the top
  logic             c_vld [NUM_SRC+1];
  logic [LVL_W-1:0] c_lvl [NUM_SRC+1];
  logic [ID_W-1:0]  c_id  [NUM_SRC+1];

  assign c_vld[0] = 1'b0;
  assign c_lvl[0] = '0;
  assign c_id[0]  = '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    irq_chain_stage #(.IDX(g)) u_stage (
      .req_i    (snap_req_q[g]),
      .lvl_i    (snap_lvl_q[g*LVL_W +: LVL_W]),
      .up_vld_i (c_vld[g]),
      .up_lvl_i (c_lvl[g]),
      .up_id_i  (c_id[g]),
      .dn_vld_o (c_vld[g+1]),
      .dn_lvl_o (c_lvl[g+1]),
      .dn_id_o  (c_id[g+1])
    );
  end

  // decision
  logic             fix_hit, msk_ok, take, take_msk;
  logic [FIX_N-1:0] fix_sel;
  logic [ID_W-1:0]  fix_id;

  always_comb begin
    fix_hit = |snap_fix_q;
    fix_sel = '0;
    fix_id  = ID_NMI;
    if (snap_fix_q[2]) begin
      fix_sel[2] = 1'b1;
      fix_id     = ID_RST;
    end else if (snap_fix_q[1]) begin
      fix_sel[1] = 1'b1;
      fix_id     = ID_WDT;
    end else if (snap_fix_q[0]) begin
      fix_sel[0] = 1'b1;
    end
    msk_ok   = c_vld[NUM_SRC] && (c_lvl[NUM_SRC] > stat_q.ipl) && !stat_q.iflag;
    take     = eval && (fix_hit || msk_ok);
    take_msk = take && !fix_hit;
  end

  // next state
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      pend_d[i] = src_set_i[i] |
                  (pend_q[i] & !(take_msk && (c_id[NUM_SRC] == ID_W'(i))));
    end
    fix_d = {rst_set_i, wdt_set_i, nmi_set_i} |
            (fix_q & ~(take && fix_hit ? fix_sel : '0));

    snap_req_d = snap_req_q;
    snap_lvl_d = snap_lvl_q;
    snap_fix_d = snap_fix_q;
    if (sample) begin
      snap_req_d = pend_q;
      snap_lvl_d = src_lvl_i;
      snap_fix_d = fix_q;
    end

    stat_d = stat_q;
    save_d = save_q;
    acc_d  = take;
    id_d   = id_q;
    if (take) begin
      save_d       = stat_q;
      stat_d.iflag = 1'b1;
      stat_d.ipl   = fix_hit ? LVL_TOP : c_lvl[NUM_SRC];
      id_d         = fix_hit ? fix_id : c_id[NUM_SRC];
    end else if (ps_wr_i) begin
      stat_d.iflag = ps_iflag_i;
      stat_d.ipl   = ps_ipl_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q     <= '0;
      fix_q      <= '0;
      snap_req_q <= '0;
      snap_lvl_q <= '0;
      snap_fix_q <= '0;
      stat_q     <= '{iflag: 1'b1, ipl: '0};
      save_q     <= '0;
      acc_q      <= 1'b0;
      id_q       <= '0;
    end else begin
      pend_q     <= pend_d;
      fix_q      <= fix_d;
      snap_req_q <= snap_req_d;
      snap_lvl_q <= snap_lvl_d;
      snap_fix_q <= snap_fix_d;
      stat_q     <= stat_d;
      save_q     <= save_d;
      acc_q      <= acc_d;
      id_q       <= id_d;
    end
  end

  assign acc_o      = acc_q;
  assign acc_id_o   = id_q;
  assign ps_save_o  = save_q;
  assign ipl_o      = stat_q.ipl;
  assign iflag_o    = stat_q.iflag;
  assign req_pend_o = pend_q;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
  import irq_prio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_o,
  input logic [ID_W-1:0]  acc_id_o,
  input logic [LVL_W:0]   ps_save_o,
  input logic [LVL_W-1:0] ipl_o,
  input logic             iflag_o
);
  // R6: accept is a single-cycle pulse
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |=> !acc_o);

  // R6: the disable flag is set together with the accept
  a_r6_iflag_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> iflag_o);

  // R6: saved status equals the status before the accept
  a_r6_save: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> (ps_save_o == {$past(iflag_o), $past(ipl_o)}));

  // R5: maskable accept needs flag clear and a level above the old one
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && acc_id_o < ID_NMI) |-> (!$past(iflag_o) && ipl_o > $past(ipl_o)));

  // R7: fixed sources raise the level to the top
  a_r7_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && acc_id_o >= ID_NMI) |-> (ipl_o == LVL_TOP));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .acc_o     (acc_o),
  .acc_id_o  (acc_id_o),
  .ps_save_o (ps_save_o),
  .ipl_o     (ipl_o),
  .iflag_o   (iflag_o)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
  localparam int N  = 18;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]   src_set;
  logic [N*3-1:0] src_lvl;
  logic nmi_set, wdt_set, rst_set, fetch, phase;
  logic [CW-1:0]  dly;
  logic ps_wr, ps_if;
  logic [2:0] ps_ipl;
  logic acc;
  logic [4:0] acc_id;
  logic [3:0] save;
  logic [2:0] ipl;
  logic iflag;
  logic [N-1:0] pend;

  always #2.5 clk = ~clk;

  irq_prio_resolver #(.NUM_SRC(N), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .src_lvl_i(src_lvl),
    .nmi_set_i(nmi_set), .wdt_set_i(wdt_set), .rst_set_i(rst_set),
    .fetch_i(fetch), .phase_hi_i(phase), .dly_sel_i(dly),
    .ps_wr_i(ps_wr), .ps_iflag_i(ps_if), .ps_ipl_i(ps_ipl),
    .acc_o(acc), .acc_id_o(acc_id), .ps_save_o(save), .ipl_o(ipl),
    .iflag_o(iflag), .req_pend_o(pend)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  int lv [N];
  bit mp [N];
  bit mf [3];   // 2 reset, 1 watchdog, 0 nmi
  bit sp [N];
  bit sf [3];
  int ipl_m = 0;
  bit i_m = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int i, input int l);
    lv[i] = l;
    src_lvl[i*3 +: 3] = 3'(l);
  endtask

  task automatic ps_write(input bit f, input int l);
    @(negedge clk);
    ps_wr = 1; ps_if = f; ps_ipl = 3'(l);
    @(negedge clk);
    ps_wr = 0;
    i_m = f; ipl_m = l;
  endtask

  task automatic raise(input int i);
    @(negedge clk);
    src_set[i] = 1'b1;
    mp[i] = 1;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic raise_fix(input bit r, input bit w, input bit nm);
    @(negedge clk);
    rst_set = r; wdt_set = w; nmi_set = nm;
    if (r) mf[2] = 1;
    if (w) mf[1] = 1;
    if (nm) mf[0] = 1;
    @(negedge clk);
    rst_set = 0; wdt_set = 0; nmi_set = 0;
  endtask

  function automatic int pend_vec();
    int v = 0;
    for (int i = 0; i < N; i++) if (mp[i]) v |= (1 << i);
    return v;
  endfunction

  // one sample and decision; late >= 0 raises that source during the wait (d >= 2)
  task automatic run_sample(input int d, input int late, input string tag);
    int wid, wl, old;
    bit take;
    for (int i = 0; i < N; i++) sp[i] = mp[i];
    for (int k = 0; k < 3; k++) sf[k] = mf[k];
    @(negedge clk);
    fetch = 1; phase = 1; dly = CW'(d);
    @(negedge clk);
    fetch = 0; phase = 0;
    for (int k = 0; k <= d; k++) begin
      if (k > 0) begin
        @(negedge clk);
        src_set = '0; fetch = 0; phase = 0;
      end
      chk(acc == 1'b0, {tag, " R8 no early accept"}, int'(acc), 0);
      if (k == 0 && d > 0) begin
        fetch = 1; phase = 1;
        if (late >= 0) begin src_set[late] = 1'b1; mp[late] = 1; end
      end
    end
    @(negedge clk);
    src_set = '0; fetch = 0; phase = 0;
    // expected decision
    wid = -1; wl = 0; take = 0;
    if (sf[2]) begin wid = 31; wl = 7; take = 1; end
    else if (sf[1]) begin wid = 30; wl = 7; take = 1; end
    else if (sf[0]) begin wid = 29; wl = 7; take = 1; end
    else begin
      for (int i = 0; i < N; i++)
        if (sp[i] && lv[i] > wl) begin wl = lv[i]; wid = i; end
      take = (wid >= 0) && (wl > ipl_m) && !i_m;
    end
    old = (int'(i_m) << 3) | ipl_m;
    chk(acc == take, {tag, " R2/R5/R7 accept"}, int'(acc), int'(take));
    if (take) begin
      chk(int'(acc_id) == wid, {tag, " R2 R3 R7 winner id"}, int'(acc_id), wid);
      chk(int'(save) == old, {tag, " R6 saved status"}, int'(save), old);
      i_m = 1; ipl_m = wl;
      if (wid < N) mp[wid] = 0; else mf[wid - 29] = 0;
    end
    chk(int'(ipl) == ipl_m, {tag, " R6 level"}, int'(ipl), ipl_m);
    chk(iflag == i_m, {tag, " R6 flag"}, int'(iflag), int'(i_m));
    chk(int'(pend) == pend_vec(), {tag, " R6/R9 pending"}, int'(pend), pend_vec());
    @(negedge clk);
    chk(acc == 1'b0, {tag, " R6 single pulse"}, int'(acc), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_set = '0; src_lvl = '0; nmi_set = 0; wdt_set = 0;
    rst_set = 0; fetch = 0; phase = 0; dly = '0; ps_wr = 0; ps_if = 0; ps_ipl = '0;
    for (int i = 0; i < N; i++) begin lv[i] = 0; mp[i] = 0; end
    for (int k = 0; k < 3; k++) mf[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(acc == 0, "R1 accept", int'(acc), 0);
    chk(ipl == 0, "R1 level", int'(ipl), 0);
    chk(iflag == 1, "R1 flag", int'(iflag), 1);
    chk(save == 0, "R1 saved", int'(save), 0);
    chk(pend == 0, "R1 pending", int'(pend), 0);

    // R8 fetch in low phase does not sample
    set_lvl(0, 3);
    ps_write(0, 0);
    raise(0);
    @(negedge clk); fetch = 1; phase = 0;
    @(negedge clk); fetch = 0;
    repeat (4) begin
      @(negedge clk);
      chk(acc == 0, "R8 low phase ignored", int'(acc), 0);
    end
    run_sample(2, -1, "R8 sample");

    // R5 equal level and flag set block the request
    set_lvl(1, 4);
    raise(1);
    ps_write(0, 4);
    run_sample(1, -1, "R5 equal level");
    ps_write(1, 0);
    run_sample(0, -1, "R5 flag set");
    ps_write(0, 3);
    run_sample(0, -1, "R5 above level");

    // R4 level zero never wins
    set_lvl(2, 0);
    raise(2);
    ps_write(0, 0);
    run_sample(1, -1, "R4 zero level");

    // R10 nesting
    set_lvl(3, 2); set_lvl(4, 5);
    raise(3);
    run_sample(0, -1, "R10 first");
    ps_write(0, 2);
    raise(4);
    run_sample(0, -1, "R10 nested");

    // R7 fixed sources
    set_lvl(5, 7);
    raise(5);
    ps_write(1, 7);
    raise_fix(0, 0, 1);
    run_sample(1, -1, "R7 nmi");
    raise_fix(0, 1, 1);
    run_sample(0, -1, "R7 wdt over nmi");
    run_sample(0, -1, "R7 nmi after wdt");
    raise_fix(1, 1, 0);
    run_sample(2, -1, "R7 reset first");
    run_sample(0, -1, "R7 wdt after reset");
    ps_write(0, 0);
    run_sample(0, -1, "R7 maskable drains");

    // R9 request raised during the wait
    set_lvl(6, 1); set_lvl(7, 6);
    raise(6);
    run_sample(3, 7, "R9 late raise");
    ps_write(0, 0);
    run_sample(0, -1, "R9 next sample");

    // R2 R3 pair sweep
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a != b) begin
          for (int i = 0; i < N; i++) set_lvl(i, 0);
          set_lvl(a, 1 + (a + 2 * b) % 7);
          set_lvl(b, (3 * a + b) % 8);
          raise(a);
          raise(b);
          ps_write((a + b) % 5 == 0, (a * b) % 3);
          run_sample((a + b) % 4, -1, "R2 R3 sweep");
          ps_write(0, 0);
          run_sample(0, -1, "R2 R3 drain");
          run_sample(1, -1, "R2 R3 drain");
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule